// File: doc/BRIEF.md
# Calendar Alarm Comparator With Per-Field Enables

This block keeps a set of alarm registers covering seconds, minutes, hours (with a PM indicator), day of week, day of month, month and year. Each register carries its own compare enable. On every seconds tick from the calendar counter it compares the enabled alarm fields against the live calendar fields. When every enabled field agrees, it latches a sticky alarm flag. Because each field can be left out of the compare, schedules such as "daily at a given hour, minute and second" or "any minute at second 30" need no extra logic.

Software writes the alarm registers through a small write port that selects a field. A new setting is trusted only after two sub-second periods, counted on an input pulse that marks each 1/64-second period. The flag is cleared by writing 0 to it. The interrupt output is the flag gated by an interrupt enable held in an external control register. The calendar counter is outside this block: it supplies the live fields and the tick pulses.

Top module: `alarm_match`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are 0 and every compare enable, including the year enable, is cleared.
- R2: A write with wr_sel 0..5 loads, in that order, seconds, minutes, hours, weekday, day and month. wr_data[7] is that field's compare enable. The value is the low BCD bits: 7 bits for seconds, minutes and hours, 3 for weekday, 6 for day and 5 for month.
- R3: On a cycle with sec_tick high, alarm_flag is set on the next clock edge when every enabled field equals its live field. Fields whose enable is 0 are ignored.
- R4: The hours compare covers bit 6, the PM indicator, so the same hour digits in AM and PM do not match each other.
- R5: With no compare enable set, alarm_flag is never set, whatever the live time.
- R6: A matching live time does not set alarm_flag on cycles where sec_tick is low.
- R7: After any alarm register write, comparison is held off until ARM_TICKS pulses of sub_tick have been seen (default 2). A seconds tick in the same cycle as a write is also ignored.
- R8: alarm_flag stays set until a cycle with clr_wr high and clr_data 0. A clear write with clr_data 1 has no effect. A set and a clear in the same cycle leave the flag set.
- R9: alarm_irq is high exactly when alarm_flag and irq_en are both high.
- R10: The year value is loaded whole (8 bits) with wr_sel 6. Its enable is loaded from wr_data[7] with wr_sel 7 and is not taken from the year value write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse after each seconds update of the calendar |
| sub_tick | input | 1 | One-cycle pulse per 1/64-second period |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 7 | Live hours, BCD in bits 5:0, PM in bit 6 |
| now_wday | input | 3 | Live day of week |
| now_day | input | 6 | Live day of month, BCD |
| now_mon | input | 5 | Live month, BCD |
| now_year | input | 8 | Live year, BCD |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 3 | Alarm register select |
| wr_data | input | 8 | Alarm register write data |
| clr_wr | input | 1 | Alarm flag write strobe |
| clr_data | input | 1 | Value written to the alarm flag (0 clears) |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with ARM_TICKS at its default of 2. Arming then takes only two sub_tick pulses, so the bench can place a seconds tick exactly at zero, one and two pulses after a write. At that value the gate's boundary, one pulse short and then just enough, falls within a few cycles. The bench also covers the field-disable, PM, year-enable and set-versus-clear orderings directly.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int ARM_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       sub_tick,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hour,
  input  logic [2:0] now_wday,
  input  logic [5:0] now_day,
  input  logic [4:0] now_mon,
  input  logic [7:0] now_year,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       clr_wr,
  input  logic       clr_data,
  input  logic       irq_en,
  output logic       alarm_flag,
  output logic       alarm_irq
);

  localparam int CW = $clog2(ARM_TICKS + 2);
  localparam logic [CW-1:0] ARM_MAX = CW'(ARM_TICKS);

  logic [6:0] sec_v, min_v, hour_v;
  logic [2:0] wday_v;
  logic [5:0] day_v;
  logic [4:0] mon_v;
  logic [7:0] year_v;
  logic       sec_e, min_e, hour_e, wday_e, day_e, mon_e, year_e;
  logic [CW-1:0] arm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_v <= '0; min_v <= '0; hour_v <= '0; wday_v <= '0;
      day_v <= '0; mon_v <= '0; year_v <= '0;
      sec_e <= 1'b0; min_e <= 1'b0; hour_e <= 1'b0; wday_e <= 1'b0;
      day_e <= 1'b0; mon_e <= 1'b0; year_e <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: begin sec_v  <= wr_data[6:0]; sec_e  <= wr_data[7]; end
        3'd1: begin min_v  <= wr_data[6:0]; min_e  <= wr_data[7]; end
        3'd2: begin hour_v <= wr_data[6:0]; hour_e <= wr_data[7]; end
        3'd3: begin wday_v <= wr_data[2:0]; wday_e <= wr_data[7]; end
        3'd4: begin day_v  <= wr_data[5:0]; day_e  <= wr_data[7]; end
        3'd5: begin mon_v  <= wr_data[4:0]; mon_e  <= wr_data[7]; end
        3'd6: year_v <= wr_data;
        default: year_e <= wr_data[7];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      arm_cnt <= ARM_MAX;
    else if (wr_en)
      arm_cnt <= '0;
    else if (sub_tick && arm_cnt != ARM_MAX)
      arm_cnt <= arm_cnt + 1'b1;
  end

  logic any_en, all_eq, armed, hit;

  assign any_en = sec_e | min_e | hour_e | wday_e | day_e | mon_e | year_e;
  assign all_eq = (!sec_e  || sec_v  == now_sec)  &&
                  (!min_e  || min_v  == now_min)  &&
                  (!hour_e || hour_v == now_hour) &&
                  (!wday_e || wday_v == now_wday) &&
                  (!day_e  || day_v  == now_day)  &&
                  (!mon_e  || mon_v  == now_mon)  &&
                  (!year_e || year_v == now_year);
  assign armed  = (arm_cnt == ARM_MAX) && !wr_en;
  assign hit    = sec_tick && armed && any_en && all_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm_flag <= 1'b0;
    else if (hit)
      alarm_flag <= 1'b1;
    else if (clr_wr && !clr_data)
      alarm_flag <= 1'b0;
  end

  assign alarm_irq = alarm_flag & irq_en;

  a_r6_set_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(alarm_flag) && alarm_flag) |-> $past(sec_tick));

  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(alarm_flag) && alarm_flag) |-> $past(any_en));

  a_r7_no_set_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(alarm_flag) && alarm_flag) |-> !$past(wr_en));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alarm_flag) && !($past(clr_wr) && !$past(clr_data))) |-> alarm_flag);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> irq_en);

endmodule

// File: tb/tb_alarm_match.sv
module tb_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, sub_tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [2:0] now_wday = '0;
  logic [5:0] now_day = '0;
  logic [4:0] now_mon = '0;
  logic [7:0] now_year = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic clr_wr = 1'b0, clr_data = 1'b0, irq_en = 1'b0;
  logic alarm_flag, alarm_irq;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  alarm_match dut (.*);

  // {sec, min, hour, wday, day, mon, year, expected}
  localparam logic [43:0] VEC [8] = '{
    {7'h30, 7'h15, 7'h47, 3'd2, 6'h11, 5'h03, 8'h24, 1'b1},
    {7'h31, 7'h15, 7'h47, 3'd2, 6'h11, 5'h03, 8'h24, 1'b0},
    {7'h30, 7'h16, 7'h47, 3'd2, 6'h11, 5'h03, 8'h24, 1'b0},
    {7'h30, 7'h15, 7'h07, 3'd2, 6'h11, 5'h03, 8'h24, 1'b0},
    {7'h30, 7'h15, 7'h47, 3'd6, 6'h28, 5'h12, 8'h99, 1'b1},
    {7'h30, 7'h15, 7'h48, 3'd2, 6'h11, 5'h03, 8'h24, 1'b0},
    {7'h00, 7'h00, 7'h00, 3'd0, 6'h00, 5'h00, 8'h00, 1'b0},
    {7'h30, 7'h15, 7'h47, 3'd0, 6'h01, 5'h01, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic subt(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic clr(input logic v);
    @(negedge clk); clr_wr = 1'b1; clr_data = v;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic set_now(input logic [43:0] v);
    {now_sec, now_min, now_hour, now_wday, now_day, now_mon, now_year} = v[43:1];
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", alarm_irq, 1'b0);

    // R5 / R1: nothing enabled after reset, any time fails to alarm
    set_now(VEC[0]);
    tick();
    check("R5 no enables", alarm_flag, 1'b0);

    // R2, R4: program sec 30, min 15, hour PM 7, others off
    wr(3'd0, 8'hB0); wr(3'd1, 8'h95); wr(3'd2, 8'hC7);
    subt(2);
    for (int i = 0; i < 8; i++) begin
      clr(1'b0);
      set_now(VEC[i]);
      tick();
      check($sformatf("R3 vector %0d", i), alarm_flag, VEC[i][0]);
    end

    // R6: matching time without a tick
    clr(1'b0);
    set_now(VEC[0]);
    repeat (5) @(negedge clk);
    check("R6 no tick", alarm_flag, 1'b0);

    // R8: sticky, write 1 ignored, write 0 clears
    tick();
    set_now(VEC[1]);
    tick();
    check("R8 sticky across mismatch", alarm_flag, 1'b1);
    clr(1'b1);
    check("R8 write 1 no effect", alarm_flag, 1'b1);

    // R9 irq gating
    check("R9 irq off", alarm_irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R9 irq on", alarm_irq, 1'b1);
    clr(1'b0);
    check("R8 clear", alarm_flag, 1'b0);
    check("R9 irq follows flag", alarm_irq, 1'b0);
    irq_en = 1'b0;

    // R8 set beats clear in same cycle
    set_now(VEC[0]);
    @(negedge clk); sec_tick = 1'b1; clr_wr = 1'b1; clr_data = 1'b0;
    @(negedge clk); sec_tick = 1'b0; clr_wr = 1'b0;
    check("R8 set wins over clear", alarm_flag, 1'b1);
    clr(1'b0);

    // R7: arming after write
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'hB0; sec_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
    check("R7 tick during write", alarm_flag, 1'b0);
    tick();
    check("R7 zero sub ticks", alarm_flag, 1'b0);
    subt(1);
    tick();
    check("R7 one sub tick", alarm_flag, 1'b0);
    subt(1);
    tick();
    check("R7 two sub ticks", alarm_flag, 1'b1);
    clr(1'b0);

    // R10: year only, enable in its own register
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h47);
    wr(3'd6, 8'hA4);
    subt(2);
    set_now(VEC[0]);
    now_year = 8'hA4;
    tick();
    check("R10 year value bit7 not enable", alarm_flag, 1'b0);
    wr(3'd6, 8'h24); wr(3'd7, 8'h80);
    subt(2);
    now_sec = 7'h59; now_hour = 7'h01; now_year = 8'h24;
    tick();
    check("R10 year only match", alarm_flag, 1'b1);
    clr(1'b0);
    now_year = 8'h25;
    tick();
    check("R10 year mismatch", alarm_flag, 1'b0);

    // R2: weekday, day, month fields
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h85); wr(3'd4, 8'hA9); wr(3'd5, 8'h91);
    subt(2);
    now_wday = 3'd5; now_day = 6'h29; now_mon = 5'h11;
    tick();
    check("R2 date fields match", alarm_flag, 1'b1);
    clr(1'b0);
    now_mon = 5'h10;
    tick();
    check("R2 month mismatch", alarm_flag, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule